// File: doc/BRIEF.md
# Split Target/Direction Next-PC Predictor

This block chooses the next fetch address in the fetch stage. Each cycle it takes the current fetch PC and looks it up in two tables at once: a small, tagged, direct-mapped target buffer that stores where taken branches went, and a much larger, untagged table of 2-bit saturating direction counters. Fetch is redirected to the stored target only when the target buffer holds a matching entry and the counter says taken. In every other case, including a cold table, fetch falls through to the sequential address.

Resolved branches come back from execute on an update port. Each update always trains the direction counter. A branch that resolved taken also writes its tag and target into the target buffer. An update that resolves not-taken leaves the target buffer alone.

The update carries the direction and target that were predicted for that branch. From these the block raises one of two one-cycle flags. A mispredict flag marks a wrong direction. A misfetch flag marks a correct taken guess that used a stale target.

Top module: `fetch_nextpc_gen`

## Requirements
- R1: Reset invalidates every target-buffer entry and sets every direction counter to weakly not-taken (value 1). After reset no lookup hits, and the first not-taken update moves a counter to 0.
- R2: `btb_hit` is 1 only when the entry selected by PC bits [6:2] is valid and its stored tag equals PC bits [14:7] (defaults). A different PC that maps to the same entry misses.
- R3: `pred_taken` is 1 only when `btb_hit` is 1 and the counter selected by PC bits [11:2] is 2 or 3. `next_pc` is then the stored target; otherwise `next_pc` is `fetch_pc + 4`.
- R4: Every update moves the addressed counter by one, up when taken and down when not-taken, saturating at 0 and 3. A taken prediction therefore survives a single not-taken outcome after training to 3.
- R5: An update that resolves taken writes the resolved PC's tag and target into its entry, replacing what was there. An update that resolves not-taken neither allocates nor invalidates an entry.
- R6: Direction counters carry no tag. Two PCs equal in bits [11:2] train and read the same counter.
- R7: `mispredict` is high for exactly the cycle after an update whose resolved direction differs from `upd_pred_taken`.
- R8: `misfetch` is high for exactly the cycle after an update that was predicted taken, resolved taken, and whose `upd_target` differs from `upd_pred_target`. It is never high together with `mispredict`.
- R9: A lookup in the same cycle as an update sees the tables as they were before that update. The update takes effect on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Redirect to the stored target |
| btb_hit | output | 1 | Target buffer holds a matching valid entry |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target address |
| upd_pred_taken | input | 1 | Direction predicted for this branch at fetch |
| upd_pred_target | input | 32 | Target predicted for this branch at fetch |
| misfetch | output | 1 | Pulse: right direction, wrong target |
| mispredict | output | 1 | Pulse: wrong direction |

## Verification
The bound checker watches several properties on every cycle. It confirms that a redirect never happens without a buffer hit and that any non-redirect gives the sequential address. It confirms that the two error flags never rise together and that each flag is caused by the matching update one cycle earlier. It also confirms that the buffer is empty on the first cycle out of reset.

Other behaviours show only across the bench's sequences of updates and lookups, because they depend on stored history. These are counter hysteresis and saturation at both ends, overwrite of a target, survival of an entry through not-taken outcomes, and eviction by a conflicting tag. They also include counter sharing between aliasing PCs, read-before-write in a same-cycle update, and counters returning to weakly not-taken after a second reset.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

   typedef logic [1:0] ctr2_t;

   localparam ctr2_t CTR_STRONG_NT = 2'd0;
   localparam ctr2_t CTR_WEAK_NT   = 2'd1;
   localparam ctr2_t CTR_WEAK_T    = 2'd2;
   localparam ctr2_t CTR_STRONG_T  = 2'd3;

   // Saturating step of a 2-bit direction counter.
   function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
      ctr2_t res;
      if (up) res = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
      else    res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return res;
   endfunction

   function automatic logic ctr_says_taken(input ctr2_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store #(
   parameter int PC_W    = 32,
   parameter int DEPTH   = 32,
   parameter int TAG_W   = 8,
   parameter int IDX_LSB = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic [PC_W-1:0] rd_target,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_target
);
   localparam int IW      = $clog2(DEPTH);
   localparam int TAG_LSB = IDX_LSB + IW;

   logic [IW-1:0]    rd_idx, wr_idx;
   logic [TAG_W-1:0] rd_tag, wr_tag;

   logic             valid_q  [DEPTH];
   logic [TAG_W-1:0] tag_q    [DEPTH];
   logic [PC_W-1:0]  target_q [DEPTH];

   assign rd_idx = rd_pc[IDX_LSB +: IW];
   assign wr_idx = wr_pc[IDX_LSB +: IW];
   assign rd_tag = rd_pc[TAG_LSB +: TAG_W];
   assign wr_tag = wr_pc[TAG_LSB +: TAG_W];

   logic unused_pc_bits;
   assign unused_pc_bits = ^{rd_pc, wr_pc};

   // One storage slot per entry; each slot owns its write decode.
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IW'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e]  <= 1'b0;
            tag_q[e]    <= '0;
            target_q[e] <= '0;
         end else if (sel) begin
            valid_q[e]  <= 1'b1;
            tag_q[e]    <= wr_tag;
            target_q[e] <= wr_target;
         end
      end
   end

   assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_target = target_q[rd_idx];

endmodule

// File: rtl/dir_table.sv
module dir_table
   import bpu_pkg::*;
#(
   parameter int    PC_W     = 32,
   parameter int    DEPTH    = 1024,
   parameter int    IDX_LSB  = 2,
   parameter ctr2_t CTR_INIT = CTR_WEAK_NT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_taken,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic            wr_taken
);
   localparam int IW = $clog2(DEPTH);

   ctr2_t         ctr_q [DEPTH];
   logic [IW-1:0] rd_idx, wr_idx;

   assign rd_idx = rd_pc[IDX_LSB +: IW];
   assign wr_idx = wr_pc[IDX_LSB +: IW];

   logic unused_pc_bits;
   assign unused_pc_bits = ^{rd_pc, wr_pc};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
      end
   end

   assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);

endmodule

// File: rtl/resolve_check.sv
module resolve_check #(
   parameter int PC_W      = 32,
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_valid,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_pred_taken,
   input  logic [PC_W-1:0] upd_pred_target,
   output logic            misfetch,
   output logic            mispredict
);
   logic dir_wrong, tgt_wrong;

   assign dir_wrong = upd_valid && (upd_taken != upd_pred_taken);
   assign tgt_wrong = upd_valid && upd_taken && upd_pred_taken
                      && (upd_target != upd_pred_target);

   if (REG_FLAGS) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            misfetch   <= 1'b0;
            mispredict <= 1'b0;
         end else begin
            misfetch   <= tgt_wrong;
            mispredict <= dir_wrong;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign misfetch   = tgt_wrong;
      assign mispredict = dir_wrong;
   end

endmodule

// File: rtl/fetch_nextpc_gen.sv
module fetch_nextpc_gen #(
   parameter int PC_W        = 32,
   parameter int BTB_DEPTH   = 32,
   parameter int DIR_DEPTH   = 1024,
   parameter int TAG_W       = 8,
   parameter int INSTR_BYTES = 4,
   parameter bit REG_FLAGS   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] next_pc,
   output logic            pred_taken,
   output logic            btb_hit,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_pred_taken,
   input  logic [PC_W-1:0] upd_pred_target,
   output logic            misfetch,
   output logic            mispredict
);
   import bpu_pkg::*;

   localparam int IDX_LSB = $clog2(INSTR_BYTES);
   localparam int BTB_IW  = $clog2(BTB_DEPTH);
   localparam int DIR_IW  = $clog2(DIR_DEPTH);

   initial begin
      assert (BTB_DEPTH == (1 << BTB_IW)) else $error("BTB_DEPTH must be a power of two");
      assert (DIR_DEPTH == (1 << DIR_IW)) else $error("DIR_DEPTH must be a power of two");
      assert (DIR_DEPTH >= BTB_DEPTH) else $error("direction table smaller than target buffer");
      assert (INSTR_BYTES == (1 << IDX_LSB)) else $error("INSTR_BYTES must be a power of two");
      assert (IDX_LSB + BTB_IW + TAG_W <= PC_W) else $error("tag field exceeds PC width");
      assert (IDX_LSB + DIR_IW <= PC_W) else $error("direction index exceeds PC width");
   end

   logic            tgt_hit;
   logic [PC_W-1:0] tgt_addr;
   logic            dir_taken;

   btb_store #(
      .PC_W(PC_W), .DEPTH(BTB_DEPTH), .TAG_W(TAG_W), .IDX_LSB(IDX_LSB)
   ) u_btb (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (fetch_pc),
      .rd_hit    (tgt_hit),
      .rd_target (tgt_addr),
      .wr_en     (upd_valid && upd_taken),
      .wr_pc     (upd_pc),
      .wr_target (upd_target)
   );

   dir_table #(
      .PC_W(PC_W), .DEPTH(DIR_DEPTH), .IDX_LSB(IDX_LSB), .CTR_INIT(CTR_WEAK_NT)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_pc    (fetch_pc),
      .rd_taken (dir_taken),
      .wr_en    (upd_valid),
      .wr_pc    (upd_pc),
      .wr_taken (upd_taken)
   );

   resolve_check #(
      .PC_W(PC_W), .REG_FLAGS(REG_FLAGS)
   ) u_res (
      .clk             (clk),
      .rst_n           (rst_n),
      .upd_valid       (upd_valid),
      .upd_taken       (upd_taken),
      .upd_target      (upd_target),
      .upd_pred_taken  (upd_pred_taken),
      .upd_pred_target (upd_pred_target),
      .misfetch        (misfetch),
      .mispredict      (mispredict)
   );

   assign btb_hit    = tgt_hit;
   assign pred_taken = tgt_hit && dir_taken;
   assign next_pc    = pred_taken ? tgt_addr : fetch_pc + PC_W'(INSTR_BYTES);

endmodule

// File: rtl/fetch_nextpc_gen_chk.sv
module fetch_nextpc_gen_chk #(
   parameter int PC_W      = 32,
   parameter int STEP      = 4,
   parameter bit REG_FLAGS = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [PC_W-1:0] next_pc,
   input logic            pred_taken,
   input logic            btb_hit,
   input logic            upd_valid,
   input logic            upd_taken,
   input logic [PC_W-1:0] upd_target,
   input logic            upd_pred_taken,
   input logic [PC_W-1:0] upd_pred_target,
   input logic            misfetch,
   input logic            mispredict
);
   logic first_q;
   always_ff @(posedge clk) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |-> (!btb_hit && !pred_taken));

   assert_redirect_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> btb_hit);

   assert_sequential_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (next_pc == fetch_pc + PC_W'(STEP)));

   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({misfetch, mispredict}));

   if (REG_FLAGS) begin : g_reg_chk
      assert_mispredict_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (mispredict && !first_q) |-> $past(upd_valid && (upd_taken != upd_pred_taken)));

      assert_misfetch_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (misfetch && !first_q) |-> $past(upd_valid && upd_taken && upd_pred_taken
                                          && (upd_target != upd_pred_target)));
   end
endmodule

bind fetch_nextpc_gen fetch_nextpc_gen_chk #(
   .PC_W(PC_W), .STEP(INSTR_BYTES), .REG_FLAGS(REG_FLAGS)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fetch_pc        (fetch_pc),
   .next_pc         (next_pc),
   .pred_taken      (pred_taken),
   .btb_hit         (btb_hit),
   .upd_valid       (upd_valid),
   .upd_taken       (upd_taken),
   .upd_target      (upd_target),
   .upd_pred_taken  (upd_pred_taken),
   .upd_pred_target (upd_pred_target),
   .misfetch        (misfetch),
   .mispredict      (mispredict)
);

// File: tb/fetch_nextpc_gen_tb_top.sv
module fetch_nextpc_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 30;

   typedef struct packed {
      logic        is_upd;
      logic [31:0] pc;
      logic        tk;
      logic [31:0] tgt;
      logic        ptk;
      logic [31:0] ptgt;
      logic [31:0] exp_npc;
      logic        exp_hit;
      logic        exp_ptk;
      logic        exp_mp;
      logic        exp_mf;
      logic [3:0]  req;
   } vec_t;

   function automatic vec_t look(logic [31:0] pc, logic [31:0] npc, logic h, logic p, logic [3:0] r);
      vec_t v = '0;
      v.pc = pc; v.exp_npc = npc; v.exp_hit = h; v.exp_ptk = p; v.req = r;
      return v;
   endfunction

   function automatic vec_t upd(logic [31:0] pc, logic tk, logic [31:0] tgt, logic ptk,
                                logic [31:0] ptgt, logic mp, logic mf, logic [3:0] r);
      vec_t v = '0;
      v.is_upd = 1'b1; v.pc = pc; v.tk = tk; v.tgt = tgt; v.ptk = ptk; v.ptgt = ptgt;
      v.exp_mp = mp; v.exp_mf = mf; v.req = r;
      return v;
   endfunction

   // Tags: R1 cold miss; R7 direction error; R3 redirect; R8 target error; R5 overwrite,
   // no invalidation on not-taken; R4 hysteresis and saturation; R2 tag conflict; R6 aliasing.
   localparam vec_t VECS [NV] = '{
      look(32'h100, 32'h104, 1'b0, 1'b0, 4'd1),
      upd (32'h100, 1'b1, 32'h400, 1'b0, 32'h0,   1'b1, 1'b0, 4'd7),
      look(32'h100, 32'h400, 1'b1, 1'b1, 4'd3),
      upd (32'h100, 1'b1, 32'h480, 1'b1, 32'h400, 1'b0, 1'b1, 4'd8),
      look(32'h100, 32'h480, 1'b1, 1'b1, 4'd5),
      upd (32'h100, 1'b0, 32'h0,   1'b1, 32'h480, 1'b1, 1'b0, 4'd7),
      look(32'h100, 32'h480, 1'b1, 1'b1, 4'd4),
      upd (32'h100, 1'b0, 32'h0,   1'b1, 32'h480, 1'b1, 1'b0, 4'd4),
      look(32'h100, 32'h104, 1'b1, 1'b0, 4'd3),
      upd (32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 4'd4),
      upd (32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 4'd4),
      look(32'h100, 32'h104, 1'b1, 1'b0, 4'd4),
      upd (32'h200, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 4'd5),
      look(32'h100, 32'h104, 1'b1, 1'b0, 4'd5),
      look(32'h200, 32'h204, 1'b0, 1'b0, 4'd2),
      upd (32'h200, 1'b1, 32'h800, 1'b1, 32'h800, 1'b0, 1'b0, 4'd4),
      upd (32'h200, 1'b1, 32'h800, 1'b1, 32'h800, 1'b0, 1'b0, 4'd4),
      upd (32'h200, 1'b1, 32'h800, 1'b1, 32'h800, 1'b0, 1'b0, 4'd4),
      upd (32'h200, 1'b1, 32'h800, 1'b1, 32'h800, 1'b0, 1'b0, 4'd4),
      look(32'h200, 32'h800, 1'b1, 1'b1, 4'd4),
      look(32'h100, 32'h104, 1'b0, 1'b0, 4'd2),
      upd (32'h200, 1'b0, 32'h0,   1'b1, 32'h800, 1'b1, 1'b0, 4'd4),
      upd (32'h200, 1'b0, 32'h0,   1'b1, 32'h800, 1'b1, 1'b0, 4'd4),
      look(32'h200, 32'h204, 1'b1, 1'b0, 4'd4),
      upd (32'h1100, 1'b1, 32'hA00, 1'b0, 32'h0,  1'b1, 1'b0, 4'd6),
      upd (32'h1100, 1'b1, 32'hA00, 1'b0, 32'h0,  1'b1, 1'b0, 4'd6),
      look(32'h1100, 32'hA00, 1'b1, 1'b1, 4'd6),
      look(32'h100,  32'h104, 1'b0, 1'b0, 4'd2),
      upd (32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 4'd6),
      look(32'h1100, 32'h1104, 1'b1, 1'b0, 4'd6)
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic [31:0] next_pc;
   logic        pred_taken, btb_hit;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic        upd_pred_taken = 1'b0;
   logic [31:0] upd_pred_target = '0;
   logic        misfetch, mispredict;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fetch_nextpc_gen dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
      .pred_taken(pred_taken), .btb_hit(btb_hit), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
      .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
      .misfetch(misfetch), .mispredict(mispredict)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_update(logic [31:0] pc, logic tk, logic [31:0] tgt,
                            logic ptk, logic [31:0] ptgt);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
      upd_pred_taken = ptk; upd_pred_target = ptgt;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic do_look(logic [31:0] pc);
      @(negedge clk);
      fetch_pc = pc;
      #1;
   endtask

   task automatic check_look(string r, logic [31:0] npc, logic h, logic p);
      chk(r, "btb_hit", {31'b0, btb_hit}, {31'b0, h});
      chk(r, "pred_taken", {31'b0, pred_taken}, {31'b0, p});
      chk(r, "next_pc", next_pc, npc);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string r;
         r = $sformatf("R%0d", VECS[i].req);
         if (VECS[i].is_upd) begin
            do_update(VECS[i].pc, VECS[i].tk, VECS[i].tgt, VECS[i].ptk, VECS[i].ptgt);
            chk(r, "mispredict", {31'b0, mispredict}, {31'b0, VECS[i].exp_mp});
            chk(r, "misfetch", {31'b0, misfetch}, {31'b0, VECS[i].exp_mf});
         end else begin
            do_look(VECS[i].pc);
            check_look(r, VECS[i].exp_npc, VECS[i].exp_hit, VECS[i].exp_ptk);
         end
      end

      // R9: same-cycle lookup and update of the same PC sees the old state.
      @(negedge clk);
      fetch_pc = 32'h3000;
      upd_valid = 1'b1; upd_pc = 32'h3000; upd_taken = 1'b1; upd_target = 32'h3400;
      upd_pred_taken = 1'b0; upd_pred_target = 32'h0;
      #1;
      check_look("R9", 32'h3004, 1'b0, 1'b0);
      @(negedge clk);
      upd_valid = 1'b0;
      #1;
      check_look("R9", 32'h3400, 1'b1, 1'b1);
      chk("R9", "mispredict", {31'b0, mispredict}, 32'd1);

      // R1: a second reset empties the buffer and returns counters to weakly not-taken.
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "mispredict", {31'b0, mispredict}, 32'd0);
      chk("R1", "misfetch", {31'b0, misfetch}, 32'd0);
      check_look("R1", 32'h3004, 1'b0, 1'b0);
      do_update(32'h3000, 1'b0, 32'h0, 1'b0, 32'h0);
      do_update(32'h3000, 1'b1, 32'h3400, 1'b0, 32'h0);
      do_look(32'h3000);
      check_look("R1", 32'h3004, 1'b1, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule